// File: doc/BRIEF.md
# Multi-Warp Instruction Issue Scheduler

This block decides, every clock cycle, which resident warps send their next instruction into a shared arithmetic pipeline. The pipeline takes several cycles to produce a result. Each warp offers one instruction at a time. The instruction names a destination register tag and two source register tags. A per-warp scoreboard marks a destination tag as busy from the cycle the instruction issues until its result is due, or until an early writeback clears it. While any tag that a warp's instruction reads or writes is busy, that warp is not a candidate. This holds even for two dependent adds in a row.

To hide the pipeline latency, the block interleaves warps. A round-robin pointer moves past the warp that issued last, so consecutive grants go to different warps whenever more than one can go. Up to two warps are granted per cycle, and the two are always different. Switching between warps costs nothing. A warp is never saved or restored; it only gains or loses eligibility. A warp that signals exit is removed from arbitration for good, until the next reset.

Top module: `wsched_top`

## Requirements
- R1: After reset all scoreboard entries are clear, no warp is exited and the pointer is 0. The first cycle with every warp requesting therefore grants warp 0 on slot 0 and warp 1 on slot 1.
- R2: A warp is eligible when `inst_valid` is high for it, it has not exited, and none of its destination, source-0 or source-1 tags is busy in its own scoreboard.
- R3: Slot 0 grants the first eligible warp found by scanning upward from the pointer, wrapping from NUM_WARPS-1 to 0.
- R4: Slot 1 grants the next eligible warp found by scanning upward from one past the slot-0 warp, excluding the slot-0 warp. It is valid only when at least two warps are eligible. `iss_valid[1]` implies `iss_valid[0]`, and the two warp IDs differ.
- R5: When any slot issues, the pointer moves to one past the last granted warp (the slot-1 warp if slot 1 issued, otherwise the slot-0 warp), with wrap. In a cycle with no issue the pointer is unchanged.
- R6: Issuing an instruction makes its destination tag busy for LATENCY-1 cycles after the issue cycle. A dependent instruction from the same warp, requested continuously, issues exactly LATENCY cycles after its producer.
- R7: A writeback (`wb_valid` with `wb_warp`, `wb_tag`) clears that tag, so the warp is eligible again in the next cycle. If an issue to the same tag happens in the same cycle, the issue wins.
- R8: A pulse on `warp_exit[w]` stops warp w from ever being granted again, starting from the next cycle, until reset.
- R9: `inst_ready[w]` is high exactly when warp w is granted on some slot in that cycle. `iss_warp[s*WARP_W +: WARP_W]` carries the binary warp index granted on slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | NUM_WARPS | Warp w offers an instruction |
| inst_dst | input | NUM_WARPS*TAG_W | Destination tag per warp, warp w at bits w*TAG_W |
| inst_src0 | input | NUM_WARPS*TAG_W | First source tag per warp |
| inst_src1 | input | NUM_WARPS*TAG_W | Second source tag per warp |
| inst_ready | output | NUM_WARPS | Warp w's instruction is issued this cycle |
| warp_exit | input | NUM_WARPS | Pulse: warp w leaves permanently |
| wb_valid | input | 1 | Writeback completion strobe |
| wb_warp | input | WARP_W | Warp of the completed result |
| wb_tag | input | TAG_W | Tag of the completed result |
| iss_valid | output | ISSUE_SLOTS | Slot s carries an issue |
| iss_warp | output | ISSUE_SLOTS*WARP_W | Warp index per slot |

## Verification
The bench builds the block with 8 warps, two issue slots and a latency of 12, but with only 4 register tags. With so few tags, random instructions hit busy tags most of the time. This exercises partial eligibility, single-slot cycles, idle cycles and pointer wrap far more often than a wide tag space would. Because the latency is 12, a full busy window of the countdown and its exact release cycle fit into short directed runs. Eight warps let the scan wrap and skip over several ineligible warps in one cycle.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;
   // Advance an index by one inside [0, n).
   function automatic int wrap_next(int idx, int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/wsched_pick.sv
`timescale 1ns/1ps
module wsched_pick #(
   parameter  int N  = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("wsched_pick: N must be at least 2");
   end

   always_comb begin
      int j;
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         j = (int'(start) + i) % N;
         if (!found && req[j]) begin
            found = 1'b1;
            idx   = IW'(j);
         end
      end
   end
endmodule

// File: rtl/wsched_sb.sv
`timescale 1ns/1ps
module wsched_sb #(
   parameter  int NUM_TAGS = 16,
   parameter  int LATENCY  = 12,
   localparam int TW       = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
   localparam int CW       = (LATENCY > 2) ? $clog2(LATENCY) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [TW-1:0] set_tag,
   input  logic          clr_en,
   input  logic [TW-1:0] clr_tag,
   input  logic [TW-1:0] q_dst,
   input  logic [TW-1:0] q_a,
   input  logic [TW-1:0] q_b,
   output logic          busy
);
   if (LATENCY < 2) begin : g_bad_lat
      $error("wsched_sb: LATENCY must be at least 2");
   end

   logic [CW-1:0]       cnt [NUM_TAGS];
   logic [NUM_TAGS-1:0] pend;

   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt[t] <= '0;
         else if (set_en && set_tag == TW'(t))
            cnt[t] <= CW'(LATENCY - 1);
         else if (clr_en && clr_tag == TW'(t))
            cnt[t] <= '0;
         else if (cnt[t] != '0)
            cnt[t] <= cnt[t] - 1'b1;
      end
      assign pend[t] = (cnt[t] != '0);

      assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
         cnt[t] <= CW'(LATENCY - 1));
      assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[t] && !(set_en && set_tag == TW'(t)) && !(clr_en && clr_tag == TW'(t)))
         |=> (cnt[t] == $past(cnt[t]) - 1'b1));
      assert_wb_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && clr_tag == TW'(t) && !(set_en && set_tag == TW'(t))) |=> !pend[t]);
   end

   assign busy = pend[q_dst] | pend[q_a] | pend[q_b];

   assert_set_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend[$past(set_tag)]);
endmodule

// File: rtl/wsched_top.sv
`timescale 1ns/1ps
module wsched_top
   import wsched_pkg::*;
#(
   parameter  int NUM_WARPS   = 8,
   parameter  int NUM_TAGS    = 16,
   parameter  int LATENCY     = 12,
   parameter  int ISSUE_SLOTS = 2,
   localparam int WARP_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int TAG_W       = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WARPS-1:0]          inst_valid,
   input  logic [NUM_WARPS*TAG_W-1:0]    inst_dst,
   input  logic [NUM_WARPS*TAG_W-1:0]    inst_src0,
   input  logic [NUM_WARPS*TAG_W-1:0]    inst_src1,
   output logic [NUM_WARPS-1:0]          inst_ready,
   input  logic [NUM_WARPS-1:0]          warp_exit,
   input  logic                          wb_valid,
   input  logic [WARP_W-1:0]             wb_warp,
   input  logic [TAG_W-1:0]              wb_tag,
   output logic [ISSUE_SLOTS-1:0]        iss_valid,
   output logic [ISSUE_SLOTS*WARP_W-1:0] iss_warp
);
   if (ISSUE_SLOTS < 1 || ISSUE_SLOTS > 2) begin : g_bad_slots
      $error("wsched_top: ISSUE_SLOTS must be 1 or 2");
   end
   if (NUM_WARPS < ISSUE_SLOTS + 1) begin : g_bad_warps
      $error("wsched_top: NUM_WARPS too small for ISSUE_SLOTS");
   end

   logic [NUM_WARPS-1:0]                 exited;
   logic [NUM_WARPS-1:0]                 busy;
   logic [NUM_WARPS-1:0]                 elig;
   logic [NUM_WARPS-1:0]                 grant;
   logic [WARP_W-1:0]                    ptr;
   logic [WARP_W-1:0]                    last_idx;
   logic [ISSUE_SLOTS-1:0]               found;
   logic [ISSUE_SLOTS-1:0][WARP_W-1:0]   idx;

   // Per-warp dependency scoreboards
   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      wsched_sb #(.NUM_TAGS(NUM_TAGS), .LATENCY(LATENCY)) u_sb (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_en  (grant[w]),
         .set_tag (inst_dst[w*TAG_W +: TAG_W]),
         .clr_en  (wb_valid && wb_warp == WARP_W'(w)),
         .clr_tag (wb_tag),
         .q_dst   (inst_dst[w*TAG_W +: TAG_W]),
         .q_a     (inst_src0[w*TAG_W +: TAG_W]),
         .q_b     (inst_src1[w*TAG_W +: TAG_W]),
         .busy    (busy[w])
      );
   end

   assign elig = inst_valid & ~exited & ~busy;

   // Slot 0: first eligible at or after the pointer
   wsched_pick #(.N(NUM_WARPS)) u_pick0 (
      .req   (elig),
      .start (ptr),
      .found (found[0]),
      .idx   (idx[0])
   );

   if (ISSUE_SLOTS == 2) begin : g_dual
      logic [NUM_WARPS-1:0] req1;
      logic [WARP_W-1:0]    start1;
      always_comb begin
         req1         = elig;
         req1[idx[0]] = 1'b0;
         start1       = WARP_W'(wrap_next(int'(idx[0]), NUM_WARPS));
      end
      wsched_pick #(.N(NUM_WARPS)) u_pick1 (
         .req   (req1),
         .start (start1),
         .found (found[1]),
         .idx   (idx[1])
      );
      assign last_idx = found[1] ? idx[1] : idx[0];

      assert_slots_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[1] |-> (iss_valid[0] && iss_warp[2*WARP_W-1:WARP_W] != iss_warp[WARP_W-1:0]));
   end else begin : g_single
      assign last_idx = idx[0];
   end

   always_comb begin
      grant = '0;
      for (int s = 0; s < ISSUE_SLOTS; s++)
         if (found[s]) grant[idx[s]] = 1'b1;
   end

   assign inst_ready = grant;
   assign iss_valid  = found;
   always_comb
      for (int s = 0; s < ISSUE_SLOTS; s++)
         iss_warp[s*WARP_W +: WARP_W] = idx[s];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         exited <= '0;
      else
         exited <= exited | warp_exit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (found[0])
         ptr <= WARP_W'(wrap_next(int'(last_idx), NUM_WARPS));
   end

   assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid[0] |=> $stable(ptr));
   assert_exit_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|warp_exit) |=> ((inst_ready & $past(warp_exit)) == '0));
   assert_ready_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(inst_ready) == $countones(iss_valid));
   assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_ready & ~inst_valid) == '0);
endmodule

// File: tb/wsched_top_tb.sv
`timescale 1ns/1ps
module wsched_top_tb;
   localparam int NW  = 8;
   localparam int NT  = 4;
   localparam int LAT = 12;
   localparam int NS  = 2;
   localparam int TW  = 2;
   localparam int WW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NW-1:0]    v, ex;
   logic [TW-1:0]    d [NW];
   logic [TW-1:0]    s0 [NW];
   logic [TW-1:0]    s1 [NW];
   logic             wbv;
   logic [WW-1:0]    wbw;
   logic [TW-1:0]    wbt;

   logic [NW*TW-1:0] f_dst, f_s0, f_s1;
   logic [NW-1:0]    inst_ready;
   logic [NS-1:0]    iss_valid;
   logic [NS*WW-1:0] iss_warp;

   always_comb
      for (int w = 0; w < NW; w++) begin
         f_dst[w*TW +: TW] = d[w];
         f_s0[w*TW +: TW]  = s0[w];
         f_s1[w*TW +: TW]  = s1[w];
      end

   wsched_top #(.NUM_WARPS(NW), .NUM_TAGS(NT), .LATENCY(LAT), .ISSUE_SLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .inst_valid(v), .inst_dst(f_dst), .inst_src0(f_s0),
      .inst_src1(f_s1), .inst_ready(inst_ready), .warp_exit(ex), .wb_valid(wbv),
      .wb_warp(wbw), .wb_tag(wbt), .iss_valid(iss_valid), .iss_warp(iss_warp));

   // Reference model state
   int mc [NW][NT];
   bit mex [NW];
   int mptr;
   int lastp0, lastp1;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int pick(logic [NW-1:0] req, int start);
      for (int i = 0; i < NW; i++)
         if (req[(start + i) % NW]) return (start + i) % NW;
      return -1;
   endfunction

   task automatic clear_inputs();
      v = '0; ex = '0; wbv = 1'b0; wbw = '0; wbt = '0;
      for (int w = 0; w < NW; w++) begin d[w] = '0; s0[w] = '0; s1[w] = '0; end
   endtask

   task automatic do_reset();
      clear_inputs();
      rst_n = 1'b0;
      for (int w = 0; w < NW; w++) begin
         mex[w] = 0;
         for (int t = 0; t < NT; t++) mc[w][t] = 0;
      end
      mptr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One cycle: compare outputs against the model, then advance the model.
   task automatic step(string tag);
      logic [NW-1:0] el, gexp;
      int p0, p1;
      #2;
      for (int w = 0; w < NW; w++)
         el[w] = v[w] && !mex[w] && mc[w][d[w]] == 0 && mc[w][s0[w]] == 0 && mc[w][s1[w]] == 0;
      p0 = pick(el, mptr);
      p1 = -1;
      if (p0 >= 0) begin el[p0] = 1'b0; p1 = pick(el, (p0 + 1) % NW); end
      gexp = '0;
      if (p0 >= 0) gexp[p0] = 1'b1;
      if (p1 >= 0) gexp[p1] = 1'b1;
      chk(tag, "iss_valid", int'(iss_valid), int'({p1 >= 0, p0 >= 0}));
      chk(tag, "inst_ready", int'(inst_ready), int'(gexp));
      if (p0 >= 0) chk(tag, "slot0 warp", int'(iss_warp[WW-1:0]), p0);
      if (p1 >= 0) chk(tag, "slot1 warp", int'(iss_warp[2*WW-1:WW]), p1);
      lastp0 = p0;
      lastp1 = p1;
      @(posedge clk);
      for (int w = 0; w < NW; w++) begin
         for (int t = 0; t < NT; t++) begin
            if (gexp[w] && int'(d[w]) == t) mc[w][t] = LAT - 1;
            else if (wbv && int'(wbw) == w && int'(wbt) == t) mc[w][t] = 0;
            else if (mc[w][t] > 0) mc[w][t] = mc[w][t] - 1;
         end
         if (ex[w]) mex[w] = 1;
      end
      if (p0 >= 0) mptr = ((p1 >= 0 ? p1 : p0) + 1) % NW;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int issues [$];
      int cnt5;
      void'($urandom(32'd24681));
      clear_inputs();
      @(negedge clk);
      do_reset();

      // R1: reset state, all warps requesting with independent tags
      step("R1 idle");
      v = '1;
      #2;
      chk("R1", "slot0 after reset", int'(iss_warp[WW-1:0]), 0);
      chk("R1", "slot1 after reset", int'(iss_warp[2*WW-1:WW]), 1);
      step("R1");

      // R6: back-to-back dependent instructions from one warp
      do_reset();
      v[2] = 1'b1; d[2] = 2'd1; s0[2] = 2'd1; s1[2] = 2'd1;
      for (int c = 0; c < 40; c++) begin
         step("R6");
         if (lastp0 == 2) issues.push_back(c);
      end
      chk("R6", "issue count", issues.size(), 4);
      for (int i = 1; i < issues.size(); i++)
         chk("R6", "dependent gap", issues[i] - issues[i-1], LAT);

      // R7: writeback releases a busy tag early
      do_reset();
      v[3] = 1'b1; d[3] = 2'd2; s0[3] = 2'd2; s1[3] = 2'd0;
      step("R7 first");
      wbv = 1'b1; wbw = 3'd3; wbt = 2'd2;
      #2;
      chk("R7", "blocked while busy", int'(iss_valid), 0);
      step("R7 wb");
      wbv = 1'b0;
      #2;
      chk("R7", "reissue after wb", int'(inst_ready), 8);
      step("R7 reissue");

      // R8: exited warp never issues again
      do_reset();
      v = '1;
      ex[5] = 1'b1;
      step("R8 pulse");
      ex = '0;
      cnt5 = 0;
      for (int c = 0; c < 40; c++) begin
         step("R8");
         if (lastp0 == 5 || lastp1 == 5) cnt5++;
      end
      chk("R8", "exited warp issues", cnt5, 0);

      // R5 and R3: pointer holds over idle cycles, scan wraps
      do_reset();
      v = 8'b0101_0000;
      step("R3");
      v = '0;
      repeat (3) step("R5 idle");
      v = 8'b1000_0011;
      #2;
      chk("R5", "slot0 after idle", int'(iss_warp[WW-1:0]), 7);
      chk("R3", "slot1 wraps", int'(iss_warp[2*WW-1:WW]), 0);
      step("R5");

      // R4: a single eligible warp gets only slot 0
      do_reset();
      v = 8'b0100_0000;
      #2;
      chk("R4", "single eligible", int'(iss_valid), 1);
      step("R4");

      // Random traffic
      do_reset();
      for (int c = 0; c < 3000; c++) begin
         v = NW'($urandom);
         for (int w = 0; w < NW; w++) begin
            d[w]  = TW'($urandom);
            s0[w] = TW'($urandom);
            s1[w] = TW'($urandom);
         end
         ex  = ($urandom % 400 == 0) ? NW'(1 << ($urandom % NW)) : '0;
         wbv = ($urandom % 3 == 0);
         wbw = WW'($urandom);
         wbt = TW'($urandom);
         step("R2 R3 R4 R9 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule